// File: doc/BRIEF.md
# Store Instruction Bus Cycle Sequencer

This block acts as a small bus master that reproduces the bus activity of a processor executing a store-accumulator instruction. It receives the address of the opcode, the accumulator byte and the 16-bit index register. After a start pulse it fetches the opcode and operand bytes from an attached memory, then writes the accumulator to the effective address. It drives one bus transaction in every active cycle.

Two addressing forms are supported. The extended form (opcode 0xB7) takes a 16-bit absolute address from the two bytes that follow the opcode, high byte first. The indexed form (opcode 0xA7) takes one unsigned offset byte, adds it to the index register and performs a dummy read of 0xFFFF before the write. The opcode fetched in the first cycle selects the form. Any other opcode ends the sequence with an error pulse. A done pulse reports the address of the next instruction.

The bus is synchronous. The memory returns read data combinationally in the same cycle in which the address is presented. `bus_rw` is 1 for a read and 0 for a write.

Top module: `store_bus_seq`

## Requirements
- R1: After reset, `bus_valid`, `done` and `err` are 0 and the block waits in idle.
- R2: In extended mode (opcode 0xB7), bus cycles 1, 2 and 3 are reads (`bus_rw`=1) of OP, OP+1 and OP+2. The first of these cycles follows the clock edge at which `start` was sampled in idle.
- R3: In extended mode, cycle 4 is a write (`bus_rw`=0) of the accumulator to {byte at OP+1, byte at OP+2}.
- R4: In indexed mode (opcode 0xA7), cycles 1, 2 and 3 are reads of OP, OP+1 and 0xFFFF. The data of the third read is unused.
- R5: In indexed mode, cycle 4 writes the accumulator to (index + zero-extended offset) mod 2^16.
- R6: Any other opcode makes `err` high for exactly one cycle, right after cycle 1. There is no further bus cycle, no write and no `done`.
- R7: `done` is high for exactly one cycle, the cycle after the write. At the same time `next_op` equals OP+3 for extended mode or OP+2 for indexed mode, modulo 2^16.
- R8: A legal sequence occupies exactly four consecutive bus cycles. A `start` that arrives while a sequence is running is ignored.
- R9: OP, the accumulator and the index are captured when `start` is accepted. Later changes on those inputs do not affect the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a sequence when the block is idle |
| op_addr | input | 16 | Address of the opcode byte |
| acc | input | 8 | Accumulator value to store |
| idx | input | 16 | Index register value |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Write data; the accumulator during the write cycle |
| bus_rdata | input | 8 | Read data returned by memory in the same cycle |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_valid | output | 1 | A bus transaction takes place this cycle |
| done | output | 1 | One-cycle pulse after the store |
| err | output | 1 | One-cycle pulse on an unsupported opcode |
| next_op | output | 16 | Address of the following instruction, valid with done |

## Verification
The assertions assume that `start` is held low for a whole sequence after launch, apart from deliberate pulses while the block is busy. They also assume that the memory answers every read in the same cycle. The bench drives `start` for one cycle per sequence and adds a single extra pulse while the block is busy. It changes the accumulator and index inputs in the middle of each sequence. Random opcode addresses are kept below 0xF000, so the operand fetches never land on the dummy address 0xFFFF and the expected read data stays unambiguous.

// File: rtl/store_bus_seq.sv
module store_bus_seq #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [7:0] OPC_EXT = 8'hB7,
  parameter logic [7:0] OPC_IDX = 8'hA7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] acc,
  input  logic [AW-1:0] idx,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_rw,
  output logic          bus_valid,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] next_op
);
  typedef enum logic [2:0] {S_IDLE = 3'd0, S_C1, S_C2, S_C3, S_C4} st_t;

  localparam logic [AW-1:0] DUMMY = {AW{1'b1}};

  st_t st;
  logic          is_idx;
  logic [AW-1:0] op_r, idx_r;
  logic [DW-1:0] acc_r, b1_r, b2_r;
  logic [AW-1:0] ea;

  assign ea = is_idx ? idx_r + AW'(b1_r) : {b1_r, b2_r};

  assign bus_valid = (st != S_IDLE);
  assign bus_rw    = (st != S_C4);
  assign bus_wdata = (st == S_C4) ? acc_r : '0;

  always_comb begin
    case (st)
      S_C1:    bus_addr = op_r;
      S_C2:    bus_addr = op_r + AW'(1);
      S_C3:    bus_addr = is_idx ? DUMMY : op_r + AW'(2);
      S_C4:    bus_addr = ea;
      default: bus_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      is_idx  <= 1'b0;
      op_r    <= '0;
      idx_r   <= '0;
      acc_r   <= '0;
      b1_r    <= '0;
      b2_r    <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      next_op <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          op_r  <= op_addr;
          acc_r <= acc;
          idx_r <= idx;
          st    <= S_C1;
        end
        S_C1: begin
          if (bus_rdata == OPC_EXT) begin
            is_idx <= 1'b0;
            st     <= S_C2;
          end else if (bus_rdata == OPC_IDX) begin
            is_idx <= 1'b1;
            st     <= S_C2;
          end else begin
            err <= 1'b1;
            st  <= S_IDLE;
          end
        end
        S_C2: begin
          b1_r <= bus_rdata;
          st   <= S_C3;
        end
        S_C3: begin
          b2_r <= bus_rdata;
          st   <= S_C4;
        end
        S_C4: begin
          done    <= 1'b1;
          next_op <= op_r + (is_idx ? AW'(2) : AW'(3));
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/store_bus_seq_chk.sv
module store_bus_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] op_addr,
  input logic [2:0]    st,
  input logic          bus_valid,
  input logic          bus_rw,
  input logic [AW-1:0] bus_addr,
  input logic          done,
  input logic          err
);
  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && start) |=> (bus_valid && bus_rw && bus_addr == $past(op_addr)));

  p_write_then_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_rw) |=> done);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_after_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($past(bus_valid && bus_rw) && !bus_valid && !done));

  p_four_cycles_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_rw) |-> ($past(bus_valid, 1) && $past(bus_valid, 2) && $past(bus_valid, 3)));

  p_quiet_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bus_valid && !err));
endmodule

bind store_bus_seq store_bus_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op_addr(op_addr), .st(st),
  .bus_valid(bus_valid), .bus_rw(bus_rw), .bus_addr(bus_addr),
  .done(done), .err(err)
);

// File: tb/test_store_bus_seq.sv
module test_store_bus_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] op_addr = '0;
  logic [7:0]  acc = '0;
  logic [15:0] idx = '0;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        bus_rw, bus_valid, done, err;
  logic [15:0] next_op;

  logic [15:0] m_op = '0;
  logic [7:0]  m_b0 = '0, m_b1 = '0, m_b2 = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  store_bus_seq i_store_bus_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_addr(op_addr), .acc(acc), .idx(idx),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rw(bus_rw),
    .bus_valid(bus_valid), .done(done), .err(err), .next_op(next_op)
  );

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    if (a == m_op) return m_b0;
    if (a == m_op + 16'd1) return m_b1;
    if (a == m_op + 16'd2) return m_b2;
    return 8'h5A;
  endfunction

  always_comb bus_rdata = mem_fn(bus_addr);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_seq(input logic [15:0] op, input logic [7:0] opc, input logic [7:0] b1,
                         input logic [7:0] b2, input logic [7:0] a, input logic [15:0] x);
    logic [15:0] la [8];
    logic [7:0]  ld [8];
    logic        lr [8];
    logic [15:0] ea [4];
    logic [7:0]  ed [4];
    logic        er [4];
    int nlog = 0, ndone = 0, nerr = 0, done_at = 0, err_at = 0;
    logic [15:0] nop_seen = '0;
    bit legal = (opc == 8'hB7) || (opc == 8'hA7);
    bit ix = (opc == 8'hA7);
    m_op = op; m_b0 = opc; m_b1 = b1; m_b2 = b2;
    ea[0] = op;           ed[0] = opc; er[0] = 1'b1;
    ea[1] = op + 16'd1;   ed[1] = b1;  er[1] = 1'b1;
    if (ix) begin
      ea[2] = 16'hFFFF;   ed[2] = mem_fn(16'hFFFF);
      ea[3] = x + {8'h00, b1};
    end else begin
      ea[2] = op + 16'd2; ed[2] = b2;
      ea[3] = {b1, b2};
    end
    er[2] = 1'b1; ed[3] = a; er[3] = 1'b0;
    op_addr = op; acc = a; idx = x; start = 1'b1;
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk);
      // R8: extra start while busy; R9: inputs change mid-sequence
      start = (c == 1);
      op_addr = 16'($urandom); acc = 8'($urandom); idx = 16'($urandom);
      if (bus_valid && nlog < 8) begin
        la[nlog] = bus_addr;
        ld[nlog] = bus_rw ? bus_rdata : bus_wdata;
        lr[nlog] = bus_rw;
        nlog++;
      end
      if (done) begin ndone++; done_at = c; nop_seen = next_op; end
      if (err) begin nerr++; err_at = c; end
    end
    start = 1'b0;
    if (legal) begin
      check("R8 bus cycle count", 32'(nlog), 32'd4);
      for (int i = 0; i < 4 && i < nlog; i++) begin
        check(ix ? (i == 3 ? "R5 write addr" : "R4 read addr") : (i == 3 ? "R3 write addr" : "R2 read addr"),
              32'(la[i]), 32'(ea[i]));
        if (!(ix && i == 2))
          check(i == 3 ? "R9 write data" : "R2 read data", 32'(ld[i]), 32'(ed[i]));
        check(i == 3 ? "R3 write rw" : "R4 read rw", 32'(lr[i]), 32'(er[i]));
      end
      check("R7 done count", 32'(ndone), 32'd1);
      check("R7 done cycle", 32'(done_at), 32'd5);
      check("R7 next_op", 32'(nop_seen), 32'(op + (ix ? 16'd2 : 16'd3)));
      check("R6 no err on legal", 32'(nerr), 32'd0);
    end else begin
      check("R6 err count", 32'(nerr), 32'd1);
      check("R6 err cycle", 32'(err_at), 32'd2);
      check("R6 single fetch", 32'(nlog), 32'd1);
      if (nlog > 0) check("R6 fetch addr", 32'(la[0]), 32'(op));
      check("R6 no done", 32'(ndone), 32'd0);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 valid at reset", 32'(bus_valid), 32'd0);
    check("R1 done at reset", 32'(done), 32'd0);
    check("R1 err at reset", 32'(err), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 32'(bus_valid), 32'd0);
    run_seq(16'h1000, 8'hB7, 8'h20, 8'h34, 8'h5C, 16'h0000);
    run_seq(16'h2000, 8'hA7, 8'h20, 8'h00, 8'hC3, 16'hFFF0);  // R5 wrap
    run_seq(16'h3000, 8'hA7, 8'hFF, 8'h00, 8'h01, 16'h0000);
    run_seq(16'h4000, 8'hB7, 8'hFF, 8'hFF, 8'hEE, 16'h1234);
    run_seq(16'hEFFE, 8'hB7, 8'h00, 8'h00, 8'h77, 16'h0000);
    run_seq(16'h5000, 8'h00, 8'h11, 8'h22, 8'h33, 16'h4444);  // R6
    run_seq(16'h6000, 8'hB6, 8'h11, 8'h22, 8'h33, 16'h4444);  // R6
    for (int k = 0; k < 40; k++) begin
      logic [7:0] opc;
      case ($urandom % 5)
        0, 1: opc = 8'hB7;
        2, 3: opc = 8'hA7;
        default: opc = 8'($urandom);
      endcase
      run_seq(16'($urandom % 32'hF000), opc, 8'($urandom), 8'($urandom),
              8'($urandom), 16'($urandom));
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule